// File: doc/BRIEF.md
# PWM Channel with Locked Update

A single-channel pulse-width modulator behind a small register file. Software programs a period count, a duty count and a control word over a simple bus with write enable, read enable, byte address, 32-bit write data and combinational read data. Once started, a counter advances on every clock of the channel and wraps after `period - 1`. The output takes the active level while the count is below the duty count and the idle level for the rest of the period. Both levels are programmable.

Writes to period, duty and the two polarity bits only go to pending copies. The generated waveform picks them up at a period boundary, which is the clock edge where the counter wraps to zero, so a period is never cut short or stretched. Setting the lock bit also stops those boundary updates. Software can then rewrite period, duty and polarity in any order. After it clears the lock, all three values take effect together at the next boundary.

A three-state controller sequences the channel. Its states are OFF, RUN and HOLD. OFF moves to RUN when the run condition becomes true with the lock clear, or to HOLD when it becomes true with the lock set. In both cases the pending values are loaded and the count starts at 0. RUN moves to HOLD when the lock is set. HOLD moves back to RUN when the lock is cleared. RUN and HOLD both return to OFF as soon as the run condition is false. Boundary updates happen only while the lock bit is clear.

Top module: `pwm_lk_channel`

## Requirements
- R1: After reset the output is low, and reads of the counter (0x00), period (0x04), duty (0x08) and control word (0x0C) all return 0.
- R2: Period and duty read back the last value written, not the value in use. The control word reads back only bits 0, 1, 3, 4, 5, 6 and 8 (mask 0x17B). Writes to the counter address are ignored. `rdata` is 0 while `rd_en` is low.
- R3: The channel runs only while control bit 0 (enable) and bit 1 (continuous) are both 1 and bit 5 (alignment) and bit 8 (low-power) are both 0. Otherwise the counter reads 0 and the output stays at the idle level.
- R4: On the first clock after the run condition becomes true, the pending values are loaded and the counter reads 0. It then reads k mod period k clocks later. A period of 0 or 1 keeps it at 0.
- R5: While running, the output is at the active level (control bit 3) when count < duty, and at the idle level (control bit 4) otherwise.
- R6: A duty of at least the period keeps the output active for the whole period. A duty of 0 keeps it idle.
- R7: Once a control write makes the run condition false, the output equals control bit 4 from the cycle after that write. From the next clock on, the counter reads 0.
- R8: With the lock clear, a period or duty write made partway through a period leaves that period unchanged and applies from the next boundary.
- R9: While control bit 6 (lock) is 1, writes to period, duty and polarity do not change the waveform, but their values read back.
- R10: After the lock is cleared, the pending period, duty and polarity all take effect together at the first boundary that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock; the counter advances once per edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational, 0 when not reading |
| pwm_out | output | 1 | PWM output pin |

## Verification
The assertions check four things on every cycle: the counter stays below a period greater than 1, a stopped channel's counter returns to 0, the values in use never change while the channel runs locked, and any change to them while running lands exactly on a wrapped count. The controller's own checks confirm that a locked run sits in HOLD and that a lost run condition reaches OFF. Only the bench's scenarios can show the actual waveform shape for each period, duty and polarity combination. They also show that readback returns pending rather than active values, and that a deferred period, duty and polarity update appears in the right cycle after unlock.

// File: rtl/pwm_lk_pkg.sv
package pwm_lk_pkg;

    // Control word bit positions (software decodes these)
    localparam int CB_EN     = 0;
    localparam int CB_CONT   = 1;
    localparam int CB_ACTHI  = 3;
    localparam int CB_IDLEHI = 4;
    localparam int CB_ALIGN  = 5;
    localparam int CB_LOCK   = 6;
    localparam int CB_LPWR   = 8;

    // Byte offsets of the registers
    localparam int REG_CNT  = 0;
    localparam int REG_PER  = 4;
    localparam int REG_DUTY = 8;
    localparam int REG_CTRL = 12;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } ch_state_e;

    typedef struct packed {
        logic act_hi;
        logic idle_hi;
    } pol_t;

    typedef struct packed {
        logic en;
        logic cont;
        logic act_hi;
        logic idle_hi;
        logic align;
        logic lock;
        logic lpwr;
    } ctrl_t;

endpackage

// File: rtl/pwm_lk_regs.sv
module pwm_lk_regs
    import pwm_lk_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [31:0]   wdata,
    input  logic [DW-1:0] cnt_i,
    output logic [31:0]   rdata,
    output logic [DW-1:0] pend_per_o,
    output logic [DW-1:0] pend_duty_o,
    output pol_t          pend_pol_o,
    output logic          run_o,
    output logic          lock_o
);

    localparam logic [AW-1:0] A_CNT  = AW'(REG_CNT);
    localparam logic [AW-1:0] A_PER  = AW'(REG_PER);
    localparam logic [AW-1:0] A_DUTY = AW'(REG_DUTY);
    localparam logic [AW-1:0] A_CTRL = AW'(REG_CTRL);

    logic [DW-1:0] per_q;
    logic [DW-1:0] duty_q;
    ctrl_t         ctl_q;
    logic [31:0]   ctl_word;

    // Writes: period, duty and control; counter address has no storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_q  <= '0;
            duty_q <= '0;
            ctl_q  <= '0;
        end else if (wr_en) begin
            if (addr == A_PER) begin
                per_q <= wdata[DW-1:0];
            end
            if (addr == A_DUTY) begin
                duty_q <= wdata[DW-1:0];
            end
            if (addr == A_CTRL) begin
                ctl_q.en      <= wdata[CB_EN];
                ctl_q.cont    <= wdata[CB_CONT];
                ctl_q.act_hi  <= wdata[CB_ACTHI];
                ctl_q.idle_hi <= wdata[CB_IDLEHI];
                ctl_q.align   <= wdata[CB_ALIGN];
                ctl_q.lock    <= wdata[CB_LOCK];
                ctl_q.lpwr    <= wdata[CB_LPWR];
            end
        end
    end

    // Rebuild the control word at its bit positions
    always_comb begin
        ctl_word            = '0;
        ctl_word[CB_EN]     = ctl_q.en;
        ctl_word[CB_CONT]   = ctl_q.cont;
        ctl_word[CB_ACTHI]  = ctl_q.act_hi;
        ctl_word[CB_IDLEHI] = ctl_q.idle_hi;
        ctl_word[CB_ALIGN]  = ctl_q.align;
        ctl_word[CB_LOCK]   = ctl_q.lock;
        ctl_word[CB_LPWR]   = ctl_q.lpwr;
    end

    // Read mux
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (addr)
                A_CNT:   rdata = 32'(cnt_i);
                A_PER:   rdata = 32'(per_q);
                A_DUTY:  rdata = 32'(duty_q);
                A_CTRL:  rdata = ctl_word;
                default: rdata = '0;
            endcase
        end
    end

    assign pend_per_o  = per_q;
    assign pend_duty_o = duty_q;
    assign pend_pol_o  = '{act_hi: ctl_q.act_hi, idle_hi: ctl_q.idle_hi};
    assign run_o       = ctl_q.en && ctl_q.cont && !ctl_q.align && !ctl_q.lpwr;
    assign lock_o      = ctl_q.lock;

endmodule

// File: rtl/pwm_lk_fsm.sv
module pwm_lk_fsm
    import pwm_lk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run_i,
    input  logic      lock_i,
    input  logic      wrap_i,
    output logic      go_o,
    output logic      load_o,
    output logic      commit_o,
    output ch_state_e st_o
);

    ch_state_e st_q;
    ch_state_e st_d;

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFF: begin
                if (run_i) begin
                    st_d = lock_i ? ST_HOLD : ST_RUN;
                end
            end
            ST_RUN: begin
                if (!run_i) begin
                    st_d = ST_OFF;
                end else if (lock_i) begin
                    st_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (!run_i) begin
                    st_d = ST_OFF;
                end else if (!lock_i) begin
                    st_d = ST_RUN;
                end
            end
            default: st_d = ST_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    // Outputs
    always_comb begin
        go_o     = 1'b0;
        load_o   = 1'b0;
        commit_o = 1'b0;
        unique case (st_q)
            ST_OFF: begin
                load_o = run_i;
            end
            ST_RUN: begin
                go_o     = run_i;
                commit_o = run_i && wrap_i && !lock_i;
            end
            ST_HOLD: begin
                go_o     = run_i;
                commit_o = run_i && wrap_i && !lock_i;
            end
            default: begin
                go_o = 1'b0;
            end
        endcase
    end

    assign st_o = st_q;

    // R9: a running channel with the lock set sits in HOLD
    p_lock_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        run_i && lock_i |=> st_q == ST_HOLD);

    // R3: losing the run condition always reaches OFF
    p_stop_to_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> st_q == ST_OFF);

endmodule

// File: rtl/pwm_lk_wave.sv
module pwm_lk_wave
    import pwm_lk_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_i,
    input  logic          load_i,
    input  logic          commit_i,
    input  logic          hold_i,
    input  logic [DW-1:0] pend_per_i,
    input  logic [DW-1:0] pend_duty_i,
    input  pol_t          pend_pol_i,
    output logic [DW-1:0] cnt_o,
    output logic          wrap_o,
    output logic          pwm_o
);

    localparam int XW = DW + 1;

    logic [DW-1:0] cnt_q;
    logic [DW-1:0] per_q;
    logic [DW-1:0] duty_q;
    pol_t          pol_q;

    // Last count of the period; a period of 0 or 1 wraps every clock
    assign wrap_o = ({1'b0, cnt_q} + XW'(1)) >= {1'b0, per_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            per_q  <= '0;
            duty_q <= '0;
            pol_q  <= '0;
        end else if (load_i) begin
            cnt_q  <= '0;
            per_q  <= pend_per_i;
            duty_q <= pend_duty_i;
            pol_q  <= pend_pol_i;
        end else if (!go_i) begin
            cnt_q <= '0;
        end else if (wrap_o) begin
            cnt_q <= '0;
            if (commit_i) begin
                per_q  <= pend_per_i;
                duty_q <= pend_duty_i;
                pol_q  <= pend_pol_i;
            end
        end else begin
            cnt_q <= cnt_q + DW'(1);
        end
    end

    always_comb begin
        if (!go_i) begin
            pwm_o = pend_pol_i.idle_hi;
        end else if (cnt_q < duty_q) begin
            pwm_o = pol_q.act_hi;
        end else begin
            pwm_o = pol_q.idle_hi;
        end
    end

    assign cnt_o = cnt_q;

    // R4: the count stays inside the period in use
    p_cnt_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        go_i && per_q > DW'(1) |-> cnt_q < per_q);

    // R7: a stopped channel returns its count to zero
    p_off_clears_cnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !go_i |=> cnt_q == '0);

    // R9: values in use are frozen while running locked
    p_frozen_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        go_i && hold_i |=> $stable(per_q) && $stable(duty_q) && $stable(pol_q));

    // R8: while running, values in use change only on a wrapped count
    p_update_at_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        go_i && $past(go_i) && (per_q != $past(per_q) || duty_q != $past(duty_q))
        |-> cnt_q == '0);

endmodule

// File: rtl/pwm_lk_channel.sv
module pwm_lk_channel
    import pwm_lk_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata,
    output logic          pwm_out
);

    logic [DW-1:0] cnt;
    logic [DW-1:0] pend_per;
    logic [DW-1:0] pend_duty;
    pol_t          pend_pol;
    logic          run;
    logic          lock;
    logic          wrap;
    logic          go;
    logic          load;
    logic          commit;
    ch_state_e     st;

    pwm_lk_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wdata      (wdata),
        .cnt_i      (cnt),
        .rdata      (rdata),
        .pend_per_o (pend_per),
        .pend_duty_o(pend_duty),
        .pend_pol_o (pend_pol),
        .run_o      (run),
        .lock_o     (lock)
    );

    pwm_lk_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run),
        .lock_i  (lock),
        .wrap_i  (wrap),
        .go_o    (go),
        .load_o  (load),
        .commit_o(commit),
        .st_o    (st)
    );

    pwm_lk_wave #(.DW(DW)) u_wave (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_i       (go),
        .load_i     (load),
        .commit_i   (commit),
        .hold_i     (lock),
        .pend_per_i (pend_per),
        .pend_duty_i(pend_duty),
        .pend_pol_i (pend_pol),
        .cnt_o      (cnt),
        .wrap_o     (wrap),
        .pwm_o      (pwm_out)
    );

    // R3: outside OFF the run condition held on the previous edge
    p_running_needs_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st != ST_OFF |-> $past(run));

endmodule

// File: tb/tb_pwm_lk_channel.sv
`timescale 1ns/1ps
module tb_pwm_lk_channel;

    localparam logic [3:0] A_CNT  = 4'h0;
    localparam logic [3:0] A_PER  = 4'h4;
    localparam logic [3:0] A_DUTY = 4'h8;
    localparam logic [3:0] A_CTRL = 4'hC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        pwm_out;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwm_lk_channel dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        addr = a; rd_en = 1'b1;
        #1;
        v = rdata;
        rd_en = 1'b0;
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic        act;
        logic        idl;
        logic        e;
        logic [31:0] run_w;
        logic [31:0] off_w;

        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        chk(pwm_out == 1'b0, "R1 output", 32'(pwm_out), 0);
        rd(A_CNT, v);  chk(v == 0, "R1 counter", v, 0);
        rd(A_PER, v);  chk(v == 0, "R1 period", v, 0);
        rd(A_DUTY, v); chk(v == 0, "R1 duty", v, 0);
        rd(A_CTRL, v); chk(v == 0, "R1 control", v, 0);

        // R2: readback, counter write ignored, idle read bus
        wr(A_CNT, 32'd5);
        rd(A_CNT, v); chk(v == 0, "R2 counter write ignored", v, 0);
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, v); chk(v == 32'h17B, "R2 control mask", v, 32'h17B);
        wr(A_CTRL, 32'h0);
        wr(A_PER, 32'hDEAD_BEEF);
        rd(A_PER, v); chk(v == 32'hDEAD_BEEF, "R2 period readback", v, 32'hDEAD_BEEF);
        addr = A_PER; #1;
        chk(rdata == 0, "R2 rdata without rd_en", rdata, 0);

        // R3: run condition not met
        wr(A_PER, 32'd3);
        wr(A_DUTY, 32'd1);
        foreach (run_w[i]) begin end
        for (int t = 0; t < 4; t++) begin
            case (t)
                0: v = 32'h009;
                1: v = 32'h00A;
                2: v = 32'h02B;
                default: v = 32'h10B;
            endcase
            wr(A_CTRL, v);
            repeat (3) tick();
            rd(A_CNT, v); chk(v == 0, "R3 counter held", v, 0);
            chk(pwm_out == 1'b0, "R3 output idle", 32'(pwm_out), 0);
        end
        wr(A_CTRL, 32'h0);

        // R4/R5/R6/R7: sweep of polarity, period and duty
        for (int pol = 0; pol < 2; pol++) begin
            for (int p = 1; p <= 6; p++) begin
                for (int d = 0; d <= 7; d++) begin
                    act   = (pol == 0);
                    idl   = (pol == 1);
                    run_w = (pol == 0) ? 32'h0B : 32'h13;
                    off_w = (pol == 0) ? 32'h08 : 32'h10;
                    wr(A_PER, 32'(p));
                    wr(A_DUTY, 32'(d));
                    wr(A_CTRL, run_w);
                    chk(pwm_out == idl, "R4 not yet started", 32'(pwm_out), 32'(idl));
                    tick();
                    for (int k = 0; k < 2 * p + 2; k++) begin
                        rd(A_CNT, v);
                        chk(v == 32'(k % p), "R4 count", v, 32'(k % p));
                        e = ((k % p) < d) ? act : idl;
                        if (d == 0 || d >= p)
                            chk(pwm_out == e, "R6 full level", 32'(pwm_out), 32'(e));
                        else
                            chk(pwm_out == e, "R5 waveform", 32'(pwm_out), 32'(e));
                        tick();
                    end
                    wr(A_CTRL, off_w);
                    chk(pwm_out == idl, "R7 idle on stop", 32'(pwm_out), 32'(idl));
                    tick();
                    rd(A_CNT, v); chk(v == 0, "R7 counter cleared", v, 0);
                end
            end
        end

        // R8: unlocked duty change mid-period waits for the boundary
        wr(A_CTRL, 32'h08);
        wr(A_PER, 32'd8);
        wr(A_DUTY, 32'd2);
        wr(A_CTRL, 32'h0B);
        tick();              // count 0
        repeat (3) tick();   // count 3
        wr(A_DUTY, 32'd6);   // count 4 afterwards
        for (int j = 4; j < 16; j++) begin
            rd(A_CNT, v);
            chk(v == 32'(j % 8), "R8 count", v, 32'(j % 8));
            e = ((j % 8) < ((j < 8) ? 2 : 6));
            chk(pwm_out == e, "R8 deferred duty", 32'(pwm_out), 32'(e));
            tick();
        end
        wr(A_CTRL, 32'h08);
        tick();

        // R9/R10: locked rewrite, then commit after unlock
        wr(A_PER, 32'd4);
        wr(A_DUTY, 32'd1);
        wr(A_CTRL, 32'h0B);
        tick();               // k=0
        wr(A_CTRL, 32'h4B);   // k=1, lock
        wr(A_PER, 32'd6);     // k=2
        wr(A_DUTY, 32'd3);    // k=3
        wr(A_CTRL, 32'h53);   // k=4, inverted pending
        rd(A_PER, v);  chk(v == 6, "R9 period readback", v, 6);
        rd(A_DUTY, v); chk(v == 3, "R9 duty readback", v, 3);
        for (int j = 0; j < 8; j++) begin
            rd(A_CNT, v);
            chk(v < 4, "R9 old period kept", v, 3);
            e = (v < 1);
            chk(pwm_out == e, "R9 old waveform kept", 32'(pwm_out), 32'(e));
            tick();
        end
        wr(A_CTRL, 32'h13);   // unlock, count 1 afterwards
        for (int j = 1; j < 4; j++) begin
            rd(A_CNT, v);
            chk(v == 32'(j), "R10 old period finishes", v, 32'(j));
            chk(pwm_out == 1'b0, "R10 old waveform finishes", 32'(pwm_out), 0);
            tick();
        end
        for (int j = 0; j < 12; j++) begin
            rd(A_CNT, v);
            chk(v == 32'(j % 6), "R10 new period", v, 32'(j % 6));
            e = ((j % 6) < 3) ? 1'b0 : 1'b1;
            chk(pwm_out == e, "R10 new duty and polarity", 32'(pwm_out), 32'(e));
            tick();
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule